// File: doc/BRIEF.md
# Step-Gated Repeated-Subtraction Divider

This block divides an unsigned dividend by an unsigned divisor by subtracting the divisor over and over. It returns a quotient and a remainder. A small controller with three states runs it: an idle state that keeps taking in the operands, a working state that makes one subtraction per enabled clock, and a finished state that holds the result until the requester confirms it has read it. A START pulse begins a division and an ACK pulse releases the result, so the two form a request/acknowledge handshake.

In the working state, a step-enable input gates both the datapath updates and the exit from that state. With the enable tied high, the division runs at one subtraction per clock. When the enable is pulsed once per debug event, the same division advances one subtraction at a time. The state diagram is the same in both cases.

Top module: `stepdiv_top`

## Requirements
- R1: A synchronous active-high reset puts the block in the idle state, so that after the reset edge st_idle_o=1, st_work_o=0, st_fin_o=0 and done_o=0. This also holds when reset arrives in the middle of a division.
- R2: In the idle state, every clock loads the working remainder from dividend_i and the divisor register from divisor_i, and clears the quotient. After such a clock, remainder_o equals the dividend that was sampled and quotient_o is 0.
- R3: In the idle state, start_i=1 moves the block to the working state on the next clock. With start_i=0 it stays idle.
- R4: In the working state with step_en_i=1, if the working remainder is greater than or equal to the divisor, the next clock subtracts the divisor from the remainder and adds 1 to the quotient, which wraps modulo 2^DATA_W.
- R5: In the working state with step_en_i=1, if the working remainder is smaller than the divisor, the next clock moves the block to the finished state and leaves quotient and remainder unchanged.
- R6: In the working state with step_en_i=0, quotient, remainder and state all hold. In the working state, start_i and ack_i have no effect.
- R7: The finished state holds quotient and remainder until ack_i=1, and the next clock after that returns the block to the idle state.
- R8: A divisor of 0 never finishes. The quotient keeps counting on every enabled step, wraps from 255 to 0, and the block stays in the working state.
- R9: Exactly one of st_idle_o, st_work_o and st_fin_o is 1 at any time, and done_o equals st_fin_o.
- R10: For a nonzero divisor, the finished state shows quotient*divisor + remainder = dividend with remainder < divisor (for example 0x58 / 0x04 gives quotient 0x16 and remainder 0x00).
- R11: With step_en_i held at 1, a division that produces quotient Q stays in the working state for exactly Q+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a division (sampled in idle) |
| ack_i | input | 1 | Release the result (sampled in finished) |
| step_en_i | input | 1 | Step enable for the working state |
| dividend_i | input | DATA_W | Dividend operand |
| divisor_i | input | DATA_W | Divisor operand |
| quotient_o | output | DATA_W | Quotient register |
| remainder_o | output | DATA_W | Working remainder register |
| st_idle_o | output | 1 | Idle state indicator |
| st_work_o | output | 1 | Working state indicator |
| st_fin_o | output | 1 | Finished state indicator |
| done_o | output | 1 | Result valid flag |

## Verification
The state, quotient and remainder registers all drive ports directly. A wrong next-state choice or a wrong datapath update therefore shows at the outputs one clock after the edge that caused it. The bench compares a behavioural model of the three registers on every clock, so a skipped subtraction, a missed step gate or an early finish shows within that single cycle. It does not have to wait for the final result. A wrong value that is only held, for example in the finished state while ack_i is low, stays visible until the handshake ends.

// File: rtl/stepdiv_pkg.sv
package stepdiv_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'b001,
    PH_WORK = 3'b010,
    PH_FIN  = 3'b100
  } phase_t;

  function automatic logic fits_under(input logic [15:0] rem, input logic [15:0] dvs);
    return rem >= dvs;
  endfunction

  function automatic logic [15:0] rem_after(input logic [15:0] rem, input logic [15:0] dvs);
    return rem - dvs;
  endfunction

endpackage

// File: rtl/stepdiv_ctrl.sv
module stepdiv_ctrl
  import stepdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start_i,
  input  logic   ack_i,
  input  logic   step_en_i,
  input  logic   fits_i,
  output phase_t phase_o
);

  phase_t phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) phase_d = PH_WORK;
      PH_WORK: if (step_en_i && !fits_i) phase_d = PH_FIN;
      PH_FIN:  if (ack_i) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  p_one_phase_r9: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_q) == 1);
  p_start_r3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && start_i) |=> phase_q == PH_WORK);
  p_gate_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_WORK && !step_en_i) |=> phase_q == PH_WORK);
  p_fin_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_FIN && !ack_i) |=> phase_q == PH_FIN);
  p_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_FIN && ack_i) |=> phase_q == PH_IDLE);

endmodule

// File: rtl/stepdiv_dpath.sv
module stepdiv_dpath
  import stepdiv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              sub_en,
  input  logic              hold_chk,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  output logic [DATA_W-1:0] rem_o,
  output logic [DATA_W-1:0] quo_o,
  output logic              fits_o
);

  localparam int PW = 16;

  logic [DATA_W-1:0] rem_q, dvs_q, quo_q;
  logic [PW-1:0]     rem_w, dvs_w, next_w;

  assign rem_w  = PW'(rem_q);
  assign dvs_w  = PW'(dvs_q);
  assign next_w = rem_after(rem_w, dvs_w);
  assign fits_o = fits_under(rem_w, dvs_w);

  always_ff @(posedge clk) begin
    if (load_en) begin
      rem_q <= dividend_i;
      dvs_q <= divisor_i;
      quo_q <= '0;
    end else if (sub_en) begin
      rem_q <= next_w[DATA_W-1:0];
      quo_q <= quo_q + 1'b1;
    end
  end

  assign rem_o = rem_q;
  assign quo_o = quo_q;

  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    sub_en |=> (quo_q == $past(quo_q) + 1'b1) && (rem_q == $past(rem_q) - $past(dvs_q)));
  p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    hold_chk |=> $stable(quo_q) && $stable(rem_q));
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    load_en |=> quo_q == '0);

endmodule

// File: rtl/stepdiv_top.sv
module stepdiv_top
  import stepdiv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              ack_i,
  input  logic              step_en_i,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  output logic [DATA_W-1:0] quotient_o,
  output logic [DATA_W-1:0] remainder_o,
  output logic              st_idle_o,
  output logic              st_work_o,
  output logic              st_fin_o,
  output logic              done_o
);

  phase_t phase;
  logic   fits;
  logic   ev_load, ev_sub, ev_finish, ev_hold;

  assign ev_load   = (phase == PH_IDLE);
  assign ev_sub    = (phase == PH_WORK) && step_en_i && fits;
  assign ev_finish = (phase == PH_WORK) && step_en_i && !fits;
  assign ev_hold   = (phase == PH_FIN) || ((phase == PH_WORK) && !step_en_i) || ev_finish;

  stepdiv_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .ack_i     (ack_i),
    .step_en_i (step_en_i),
    .fits_i    (fits),
    .phase_o   (phase)
  );

  stepdiv_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk        (clk),
    .rst        (rst),
    .load_en    (ev_load),
    .sub_en     (ev_sub),
    .hold_chk   (ev_hold),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .rem_o      (remainder_o),
    .quo_o      (quotient_o),
    .fits_o     (fits)
  );

  assign st_idle_o = phase[0];
  assign st_work_o = phase[1];
  assign st_fin_o  = phase[2];
  assign done_o    = phase[2];

  p_fin_remainder_r10: assert property (@(posedge clk) disable iff (rst)
    ev_finish |=> st_fin_o);
  p_zero_divisor_r8: assert property (@(posedge clk) disable iff (rst)
    (st_work_o && step_en_i && !ev_finish) |=> st_work_o);

endmodule

// File: tb/stepdiv_tb.sv
module stepdiv_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0, ack_i = 1'b0, step_en_i = 1'b0;
  logic [7:0] dividend_i = 8'h00, divisor_i = 8'h00;
  logic [7:0] quotient_o, remainder_o;
  logic       st_idle_o, st_work_o, st_fin_o, done_o;

  int total = 0;
  int bad = 0;

  // behavioural model: 0 idle, 1 working, 2 finished
  int m_ph = 0;
  int m_rem = 0, m_dvs = 0, m_quo = 0;
  bit m_valid = 0;

  always #4 clk = ~clk;

  stepdiv_top #(.DATA_W(8)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .ack_i(ack_i), .step_en_i(step_en_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .quotient_o(quotient_o), .remainder_o(remainder_o),
    .st_idle_o(st_idle_o), .st_work_o(st_work_o), .st_fin_o(st_fin_o), .done_o(done_o)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0;
      m_valid = 0;
    end else begin
      case (m_ph)
        0: begin
          m_rem = int'(dividend_i); m_dvs = int'(divisor_i); m_quo = 0; m_valid = 1;
          if (start_i) m_ph = 1;
        end
        1: if (step_en_i) begin
          if (m_rem < m_dvs) m_ph = 2;
          else begin
            m_rem = m_rem - m_dvs;
            m_quo = (m_quo + 1) % 256;
          end
        end
        default: if (ack_i) m_ph = 0;
      endcase
    end
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    int exp_ind;
    exp_ind = (m_ph == 0) ? 1 : (m_ph == 1) ? 2 : 4;
    check_eq("R9 state indicators", int'({st_fin_o, st_work_o, st_idle_o}), exp_ind);
    check_eq("R9 done flag", int'(done_o), int'(st_fin_o));
    if (m_valid) begin
      check_eq("R4 quotient vs model", int'(quotient_o), m_quo);
      check_eq("R4 remainder vs model", int'(remainder_o), m_rem);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare_model();
  endtask

  task automatic run_div(input logic [7:0] a, input logic [7:0] b, output int work_cycles);
    dividend_i = a; divisor_i = b; step_en_i = 1'b1;
    tick();
    check_eq("R2 idle loads dividend", int'(remainder_o), int'(a));
    check_eq("R2 idle clears quotient", int'(quotient_o), 0);
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    check_eq("R3 start enters working", int'(st_work_o), 1);
    work_cycles = 1;
    for (int k = 0; k < 400 && !st_fin_o; k++) begin
      tick();
      if (st_work_o) work_cycles++;
    end
  endtask

  task automatic release_result();
    ack_i = 1'b1;
    tick();
    ack_i = 1'b0;
    check_eq("R7 ack returns to idle", int'(st_idle_o), 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stimulus
    int cyc;
    bit saw_top, saw_wrap;
    rst = 1'b1;
    repeat (3) tick();
    check_eq("R1 reset idle", int'({st_fin_o, st_work_o, st_idle_o, done_o}), 4'b0010);
    rst = 1'b0;
    tick();

    // R10 / R11: example division at full rate
    run_div(8'h58, 8'h04, cyc);
    check_eq("R10 quotient 0x58/4", int'(quotient_o), 8'h16);
    check_eq("R10 remainder 0x58/4", int'(remainder_o), 0);
    check_eq("R11 working cycles", cyc, 8'h16 + 1);
    repeat (3) tick();
    check_eq("R7 finished holds quotient", int'(quotient_o), 8'h16);
    check_eq("R7 finished holds without ack", int'(st_fin_o), 1);
    release_result();

    // R3: no start means stay idle
    repeat (2) tick();
    check_eq("R3 idle without start", int'(st_idle_o), 1);

    // R6: gated stepping, start/ack ignored while working
    dividend_i = 8'd23; divisor_i = 8'd5; step_en_i = 1'b0;
    tick();
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    for (int k = 0; k < 60 && !st_fin_o; k++) begin
      step_en_i = (k % 3 == 2);
      ack_i = (k % 4 == 1);
      start_i = (k % 5 == 0);
      tick();
      if (k == 0) begin
        check_eq("R6 no step quotient hold", int'(quotient_o), 0);
        check_eq("R6 ack ignored in working", int'(st_work_o), 1);
      end
    end
    step_en_i = 1'b0; ack_i = 1'b0; start_i = 1'b0;
    tick();
    check_eq("R10 quotient 23/5", int'(quotient_o), 4);
    check_eq("R10 remainder 23/5", int'(remainder_o), 3);
    release_result();

    // R5: divisor larger than dividend
    run_div(8'd3, 8'd9, cyc);
    check_eq("R5 quotient 3/9", int'(quotient_o), 0);
    check_eq("R5 remainder 3/9", int'(remainder_o), 3);
    release_result();

    // boundaries
    run_div(8'hFF, 8'h01, cyc);
    check_eq("R10 quotient 255/1", int'(quotient_o), 255);
    check_eq("R11 cycles 255/1", cyc, 256);
    release_result();
    run_div(8'hFF, 8'hFF, cyc);
    check_eq("R10 quotient 255/255", int'(quotient_o), 1);
    check_eq("R10 remainder 255/255", int'(remainder_o), 0);
    release_result();

    // R8: divide by zero wraps and never finishes
    dividend_i = 8'd7; divisor_i = 8'd0; step_en_i = 1'b1;
    tick();
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    saw_top = 0; saw_wrap = 0;
    for (int k = 0; k < 300; k++) begin
      tick();
      if (quotient_o == 8'hFF) saw_top = 1;
      if (saw_top && quotient_o == 8'h00) saw_wrap = 1;
    end
    check_eq("R8 quotient wrapped", int'(saw_wrap), 1);
    check_eq("R8 still working", int'(st_work_o), 1);

    // R1: reset during a division
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check_eq("R1 reset mid-division", int'({st_fin_o, st_work_o, st_idle_o}), 3'b001);
    tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule